// File: doc/BRIEF.md
# Patchable Instruction Fetch Redirector

This block is the fetch front end of a small embedded core whose program lives in a mask ROM, with a small writable patch memory next to it. A fully associative link table holds pairs of a ROM trigger address and a patch start address. Every ROM fetch address is compared against all table entries in the same cycle as the ROM is read. When an entry matches, the instruction at the trigger address is still delivered. The very next fetch then comes from the patch memory at the stored patch address, with no lost cycle.

Patch code runs sequentially in its own address space. It returns to ROM only through a core redirect, which is the final jump or branch of the patch. The table sits in volatile registers. After reset, a serial loader writes every entry, one per cycle, from a non-volatile copy. Fetching is held until all entries have been written.

Fetch addresses are LOW_W+1 bits wide, where LOW_W = max(ROM_AW, PAT_AW). The top bit selects the space: 0 for ROM and 1 for patch. The low bits are the word index within that space.

Top module: `patch_fetch_redirect`

## Requirements
- R1: After reset, `ready` and `out_valid` are 0, every table entry is invalid, and no fetch is delivered while `ready` is 0.
- R2: A loader write (`ld_we`=1) stores {`ld_valid`, `ld_rom`, `ld_pat`} in entry `ld_idx`. `ready` rises in the cycle after the edge on which the last not-yet-written index is written, and it stays high. Rewriting an index that is already written does not raise `ready`.
- R3: Loader writes made while `ready` is 1 are ignored and leave the table unchanged.
- R4: Once `ready` is 1, fetching starts at ROM address 0 and advances by one word per cycle. Each delivered word appears one cycle after its address was presented, together with `out_addr` (that address) and `out_src` (0 for ROM, 1 for patch).
- R5: A ROM fetch that matches a valid entry is still delivered. The next delivered fetch is patch address = that entry's patch field, with `out_src`=1 and no gap cycle.
- R6: When several valid entries match, the entry with the lowest index supplies the patch address.
- R7: Entries whose valid bit is 0 never match.
- R8: Fetches in patch space (address bit LOW_W = 1) never consult the table. A patch address that is numerically equal to a trigger does not redirect.
- R9: A core redirect (`redir_valid`=1) sets the next fetch address to `redir_addr`, which takes priority over both the sequential address and a table hit. The fetch already presented is still delivered.
- R10: Sequential fetch wraps within its own space: ROM from 2^ROM_AW-1 to 0, and patch from 2^PAT_AW-1 to patch 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redir_valid | input | 1 | Core redirect request |
| redir_addr | input | LOW_W+1 | Redirect target fetch address |
| ld_we | input | 1 | Loader write enable |
| ld_idx | input | IDX_W | Loader entry index |
| ld_valid | input | 1 | Loaded entry valid bit |
| ld_rom | input | ROM_AW | Loaded ROM trigger address |
| ld_pat | input | PAT_AW | Loaded patch start address |
| ready | output | 1 | Table fully loaded, fetch running |
| rom_rd | output | 1 | ROM read enable |
| rom_addr | output | ROM_AW | ROM read address |
| rom_data | input | IW | ROM word, one cycle after the address |
| pat_rd | output | 1 | Patch memory read enable |
| pat_addr | output | PAT_AW | Patch memory read address |
| pat_data | input | IW | Patch word, one cycle after the address |
| out_valid | output | 1 | Delivered word valid |
| out_instr | output | IW | Delivered instruction word |
| out_addr | output | LOW_W+1 | Fetch address of the delivered word |
| out_src | output | 1 | 0 = ROM, 1 = patch memory |

## Verification
The hardest case to reach is a table hit that arrives in the same cycle as a core redirect. Producing it needs the bench to know exactly which address is presented while a given word is being delivered. The bench drives the redirect on the cycle whose delivered word is the one just before a trigger, so the redirect lands on the cycle in which the trigger is presented. The bench also creates duplicate and invalid entries, and a patch address equal to a trigger, in a four-entry table. It then walks through both wrap points, predicting every delivered address from the loaded contents.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  typedef enum logic {SRC_ROM = 1'b0, SRC_PATCH = 1'b1} fetch_src_e;
endpackage

// File: rtl/pfr_link_table.sv
module pfr_link_table #(
  parameter int ENTRIES = 64,
  parameter int ROM_AW  = 16,
  parameter int PAT_AW  = 10,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             ld_we,
  input  logic [IDX_W-1:0]                 ld_idx,
  input  logic                             ld_valid,
  input  logic [ROM_AW-1:0]                ld_rom,
  input  logic [PAT_AW-1:0]                ld_pat,
  output logic [ENTRIES-1:0]               ent_valid,
  output logic [ENTRIES-1:0][ROM_AW-1:0]   ent_rom,
  output logic [ENTRIES-1:0][PAT_AW-1:0]   ent_pat,
  output logic                             ready
);
  logic [ENTRIES-1:0] written_q;
  logic               we_eff;

  assign we_eff = ld_we & ~ready;
  assign ready  = &written_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_valid[g] <= 1'b0;
        written_q[g] <= 1'b0;
      end else if (we_eff && ld_idx == IDX_W'(g)) begin
        ent_valid[g] <= ld_valid;
        written_q[g] <= 1'b1;
      end
    end
    always_ff @(posedge clk) begin
      if (we_eff && ld_idx == IDX_W'(g)) begin
        ent_rom[g] <= ld_rom;
        ent_pat[g] <= ld_pat;
      end
    end
  end

  assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);
  assert_frozen_after_ready_R3: assert property (@(posedge clk) disable iff (rst)
    ready |=> ($stable(ent_valid) && $stable(ent_rom) && $stable(ent_pat)));
endmodule

// File: rtl/pfr_match.sv
module pfr_match #(
  parameter int ENTRIES = 64,
  parameter int ROM_AW  = 16,
  parameter int PAT_AW  = 10
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             en,
  input  logic [ROM_AW-1:0]                addr,
  input  logic [ENTRIES-1:0]               ent_valid,
  input  logic [ENTRIES-1:0][ROM_AW-1:0]   ent_rom,
  input  logic [ENTRIES-1:0][PAT_AW-1:0]   ent_pat,
  output logic                             hit,
  output logic [PAT_AW-1:0]                hit_pat
);
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] sel_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = en & ent_valid[g] & (ent_rom[g] == addr);
  end

  always_comb begin
    hit     = 1'b0;
    hit_pat = '0;
    sel_vec = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        hit        = 1'b1;
        hit_pat    = ent_pat[i];
        sel_vec    = '0;
        sel_vec[i] = 1'b1;
      end
    end
  end

  assert_single_pick_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_vec));
  assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (rst)
    hit |-> ((match_vec & (sel_vec - 1'b1)) == '0));
  assert_invalid_silent_R7: assert property (@(posedge clk) disable iff (rst)
    ((sel_vec & ~ent_valid) == '0));
endmodule

// File: rtl/pfr_next_pc.sv
module pfr_next_pc #(
  parameter int ROM_AW = 16,
  parameter int PAT_AW = 10,
  localparam int LOW_W = (ROM_AW > PAT_AW) ? ROM_AW : PAT_AW,
  localparam int FA_W  = LOW_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ready,
  input  logic              redir_valid,
  input  logic [FA_W-1:0]   redir_addr,
  input  logic              hit,
  input  logic [PAT_AW-1:0] hit_pat,
  output logic [FA_W-1:0]   pc
);
  logic              in_patch;
  logic [ROM_AW-1:0] rom_inc;
  logic [PAT_AW-1:0] pat_inc;
  logic [FA_W-1:0]   pc_seq;
  logic [FA_W-1:0]   pc_nxt;

  assign in_patch = pc[LOW_W];
  assign rom_inc  = pc[ROM_AW-1:0] + 1'b1;
  assign pat_inc  = pc[PAT_AW-1:0] + 1'b1;

  always_comb begin
    if (in_patch) pc_seq = {1'b1, LOW_W'(pat_inc)};
    else          pc_seq = {1'b0, LOW_W'(rom_inc)};
    if (redir_valid)  pc_nxt = redir_addr;
    else if (hit)     pc_nxt = {1'b1, LOW_W'(hit_pat)};
    else              pc_nxt = pc_seq;
  end

  always_ff @(posedge clk) begin
    if (rst)        pc <= '0;
    else if (ready) pc <= pc_nxt;
  end

  assert_hold_unready_R1: assert property (@(posedge clk) disable iff (rst)
    !ready |=> (pc == $past(pc)));
  assert_redirect_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (ready && redir_valid) |=> (pc == $past(redir_addr)));
  assert_hit_jump_R5: assert property (@(posedge clk) disable iff (rst)
    (ready && !redir_valid && hit) |=>
      (pc[LOW_W] && pc[PAT_AW-1:0] == $past(hit_pat)));
  assert_patch_stays_R8: assert property (@(posedge clk) disable iff (rst)
    (ready && !redir_valid && in_patch) |=> pc[LOW_W]);
endmodule

// File: rtl/patch_fetch_redirect.sv
module patch_fetch_redirect
  import pfr_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int ROM_AW  = 16,
  parameter int PAT_AW  = 10,
  parameter int IW      = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int LOW_W  = (ROM_AW > PAT_AW) ? ROM_AW : PAT_AW,
  localparam int FA_W   = LOW_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              redir_valid,
  input  logic [FA_W-1:0]   redir_addr,
  input  logic              ld_we,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic              ld_valid,
  input  logic [ROM_AW-1:0] ld_rom,
  input  logic [PAT_AW-1:0] ld_pat,
  output logic              ready,
  output logic              rom_rd,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [IW-1:0]     rom_data,
  output logic              pat_rd,
  output logic [PAT_AW-1:0] pat_addr,
  input  logic [IW-1:0]     pat_data,
  output logic              out_valid,
  output logic [IW-1:0]     out_instr,
  output logic [FA_W-1:0]   out_addr,
  output logic              out_src
);
  logic [ENTRIES-1:0]             ent_valid;
  logic [ENTRIES-1:0][ROM_AW-1:0] ent_rom;
  logic [ENTRIES-1:0][PAT_AW-1:0] ent_pat;
  logic                           hit;
  logic [PAT_AW-1:0]              hit_pat;
  logic [FA_W-1:0]                pc;
  logic                           lookup_en;
  fetch_src_e                     src_q;

  pfr_link_table #(.ENTRIES(ENTRIES), .ROM_AW(ROM_AW), .PAT_AW(PAT_AW)) u_table (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_idx(ld_idx), .ld_valid(ld_valid),
    .ld_rom(ld_rom), .ld_pat(ld_pat), .ent_valid(ent_valid), .ent_rom(ent_rom),
    .ent_pat(ent_pat), .ready(ready)
  );

  assign lookup_en = ready & ~pc[LOW_W];

  pfr_match #(.ENTRIES(ENTRIES), .ROM_AW(ROM_AW), .PAT_AW(PAT_AW)) u_match (
    .clk(clk), .rst(rst), .en(lookup_en), .addr(pc[ROM_AW-1:0]),
    .ent_valid(ent_valid), .ent_rom(ent_rom), .ent_pat(ent_pat),
    .hit(hit), .hit_pat(hit_pat)
  );

  pfr_next_pc #(.ROM_AW(ROM_AW), .PAT_AW(PAT_AW)) u_pc (
    .clk(clk), .rst(rst), .ready(ready), .redir_valid(redir_valid),
    .redir_addr(redir_addr), .hit(hit), .hit_pat(hit_pat), .pc(pc)
  );

  assign rom_rd   = ready & ~pc[LOW_W];
  assign pat_rd   = ready &  pc[LOW_W];
  assign rom_addr = pc[ROM_AW-1:0];
  assign pat_addr = pc[PAT_AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      src_q     <= SRC_ROM;
    end else begin
      out_valid <= ready;
      if (ready) begin
        out_addr <= pc;
        src_q    <= pc[LOW_W] ? SRC_PATCH : SRC_ROM;
      end
    end
  end

  assign out_src   = src_q;
  assign out_instr = (src_q == SRC_PATCH) ? pat_data : rom_data;

  assert_no_fetch_unready_R1: assert property (@(posedge clk) disable iff (rst)
    !ready |=> !out_valid);
  assert_src_tag_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_src == out_addr[LOW_W]));
endmodule

// File: tb/patch_fetch_redirect_test.sv
`timescale 1ns/1ps
module patch_fetch_redirect_test;
  localparam int ENTRIES = 4;
  localparam int ROM_AW  = 6;
  localparam int PAT_AW  = 4;
  localparam int IW      = 16;
  localparam int IDX_W   = 2;
  localparam int FA_W    = 7;
  localparam int PB      = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic redir_valid = 1'b0;
  logic [FA_W-1:0] redir_addr = '0;
  logic ld_we = 1'b0;
  logic [IDX_W-1:0] ld_idx = '0;
  logic ld_valid = 1'b0;
  logic [ROM_AW-1:0] ld_rom = '0;
  logic [PAT_AW-1:0] ld_pat = '0;
  logic ready, rom_rd, pat_rd, out_valid, out_src;
  logic [ROM_AW-1:0] rom_addr;
  logic [PAT_AW-1:0] pat_addr;
  logic [IW-1:0] rom_data, pat_data, out_instr;
  logic [FA_W-1:0] out_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [IW-1:0] rom_word(int a);
    return IW'(16'hA000 ^ (a * 37));
  endfunction
  function automatic logic [IW-1:0] pat_word(int p);
    return IW'(16'h5000 ^ (p * 11 + 1));
  endfunction

  always_ff @(posedge clk) begin
    if (rom_rd) rom_data <= rom_word(int'(rom_addr));
    if (pat_rd) pat_data <= pat_word(int'(pat_addr));
  end

  patch_fetch_redirect #(.ENTRIES(ENTRIES), .ROM_AW(ROM_AW), .PAT_AW(PAT_AW), .IW(IW)) uut (
    .clk(clk), .rst(rst), .redir_valid(redir_valid), .redir_addr(redir_addr),
    .ld_we(ld_we), .ld_idx(ld_idx), .ld_valid(ld_valid), .ld_rom(ld_rom), .ld_pat(ld_pat),
    .ready(ready), .rom_rd(rom_rd), .rom_addr(rom_addr), .rom_data(rom_data),
    .pat_rd(pat_rd), .pat_addr(pat_addr), .pat_data(pat_data),
    .out_valid(out_valid), .out_instr(out_instr), .out_addr(out_addr), .out_src(out_src)
  );

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic load(input int idx, input bit v, input int ra, input int pa);
    ld_we = 1'b1; ld_idx = IDX_W'(idx); ld_valid = v;
    ld_rom = ROM_AW'(ra); ld_pat = PAT_AW'(pa);
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  // Outputs now should show fetch ea (ROM index, or PB + patch index);
  // rv/ra set the redirect applied at the next edge.
  task automatic step(input int ea, input bit rv, input int ra, input string tag);
    logic [IW-1:0] ew;
    logic          es;
    es = (ea >= PB);
    ew = es ? pat_word(ea - PB) : rom_word(ea);
    checks++;
    if (out_valid !== 1'b1 || out_addr !== FA_W'(ea) || out_src !== es || out_instr !== ew) begin
      fails++;
      $display("FAIL %s: got v=%0b addr=%0d src=%0b instr=%h expected v=1 addr=%0d src=%0b instr=%h",
               tag, out_valid, out_addr, out_src, out_instr, ea, es, ew);
    end
    redir_valid = rv;
    redir_addr  = FA_W'(ra);
    @(negedge clk);
    redir_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_bit("R1 ready after reset", ready, 1'b0);
    check_bit("R1 out_valid after reset", out_valid, 1'b0);
    // entry0 and entry1 share trigger 5 (lowest index wins), entry2 invalid
    load(0, 1'b1, 5, 3);
    load(1, 1'b1, 5, 9);
    load(2, 1'b0, 10, 7);
    load(0, 1'b1, 5, 3);
    check_bit("R2 ready low with index 3 unwritten", ready, 1'b0);
    check_bit("R1 no fetch during load", out_valid, 1'b0);
    load(3, 1'b1, 20, 12);
    check_bit("R2 ready after last index", ready, 1'b1);
    check_bit("R4 nothing delivered yet", out_valid, 1'b0);
    // R3: this write arrives after ready and must be ignored (ROM 31 -> patch 0)
    load(0, 1'b1, 31, 0);
    for (int a = 0; a < 5; a++) step(a, 1'b0, 0, "R4 sequential ROM");
    step(5, 1'b0, 0, "R5 trigger still delivered");
    step(PB + 3, 1'b0, 0, "R5_R6 hit goes to lowest-index patch 3");
    step(PB + 4, 1'b0, 0, "R5 patch sequential");
    step(PB + 5, 1'b0, 0, "R8 patch 5 is not a trigger");
    step(PB + 6, 1'b1, 8, "R8 patch sequential");
    step(PB + 7, 1'b0, 0, "R9 in-flight word delivered");
    step(8, 1'b0, 0, "R9 redirect back to ROM");
    step(9, 1'b0, 0, "R4 sequential ROM");
    step(10, 1'b0, 0, "R7 invalid entry trigger");
    for (int a = 11; a <= 20; a++) step(a, 1'b0, 0, "R7 no jump from invalid entry");
    step(PB + 12, 1'b0, 0, "R5 entry3 hit");
    step(PB + 13, 1'b0, 0, "R10 patch run");
    step(PB + 14, 1'b0, 0, "R10 patch run");
    step(PB + 15, 1'b0, 0, "R10 patch top");
    step(PB + 0, 1'b1, 4, "R10 patch wrap to 0");
    step(PB + 1, 1'b0, 0, "R9 in-flight word delivered");
    step(4, 1'b1, 30, "R9 redirect back to ROM 4");
    step(5, 1'b0, 0, "R9 trigger presented with redirect");
    step(30, 1'b0, 0, "R9 redirect beats hit");
    step(31, 1'b1, 63, "R3 ignored entry at 31");
    step(32, 1'b0, 0, "R3 no jump from ROM 31");
    step(63, 1'b0, 0, "R9 redirect to ROM top");
    step(0, 1'b0, 0, "R10 ROM wrap to 0");
    check_bit("R2 ready stays high", ready, 1'b1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule